// File: doc/BRIEF.md
# Dual-Latch Interval Timer

This block is a 16-bit down-counter placed behind a small byte-wide register window of four addresses. Two 8-bit holding latches store the reload value. Software never writes the low counter byte directly. Instead, a write to the start address places the written byte into both the high latch and the high counter byte. The same write copies the low latch into the low counter byte and begins the countdown. Two further addresses update the latches alone, so the value for the next reload can be prepared while a count is still running.

Each terminal count raises an interrupt flag. In one-shot mode the flag is raised once per start. The counter then wraps and keeps counting down, so software can read how much time has passed since the interrupt. In free-running mode every terminal count reloads the counter from both latches, which gives a periodic interrupt. When the pin is enabled, the timer drives a dedicated output pin. In one-shot mode the pin carries one low pulse whose width is set by the loaded value. In free-running mode the pin toggles at each terminal count and forms a square wave. When the pin is not enabled, the pin simply carries a general-purpose output bit.

Top module: `dlt_timer`

## Requirements
- R1: After reset the counter and both latches read 0, `irq_flag` is 0, and the timer's pin state is high. With `mode[1]`=1, `pin_out` reads 1.
- R2: A write to address 0 or address 2 loads the low latch. A write to address 3 loads the high latch. Writes to addresses 2 and 3 leave a running count untouched. Reads of addresses 2 and 3 return the low and high latch bytes.
- R3: A write of byte D to address 1 loads the high latch with D and loads the counter with {D, low latch}. It also clears `irq_flag` and starts the count. Reads of address 0 and address 1 return the low and high counter bytes.
- R4: The counter decrements by one on each clock where `tick_en`=1. It holds its value while `tick_en`=0.
- R5: Terminal count is a tick taken while the counter is 0x0000. After a start that loads N, the flag rises on the N+1-th tick.
- R6: `mode[0]`=0 selects one-shot mode. At terminal count the counter wraps to 0xFFFF and keeps decrementing. The flag cannot rise again until the next start write.
- R7: `mode[0]`=1 selects free-running mode. Each terminal count reloads the counter from both latches as they stand at that tick, so the flag repeats every N+1 ticks.
- R8: `irq_flag` is cleared by a read of address 0, by a write to address 1 or address 3, and by `flag_clr`=1. If a terminal count happens in the same cycle as a clear, the flag is set.
- R9: The timer's pin state goes low in the cycle after a start write. In one-shot mode it returns high at terminal count. In free-running mode it inverts at each terminal count.
- R10: With `mode[1]`=1, `pin_oe`=1 and `pin_out` follows the timer and ignores `gpio_bit`. With `mode[1]`=0, `pin_oe`=0 and `pin_out` equals `gpio_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable; one decrement per enabled clock |
| sel | input | 1 | Register access select |
| addr | input | 2 | Register address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte; 0 when not reading |
| mode | input | 2 | Bit 0: free-running; bit 1: pin driven by the timer |
| gpio_bit | input | 1 | Ordinary output-register bit used when the pin is not enabled |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| pin_out | output | 1 | Timer output pin value |
| pin_oe | output | 1 | Output enable for the timer pin |

## Verification
A start write takes effect at the clock edge that accepts it, so the loaded count and the low pin level can be seen one cycle later. The flag is due exactly N+1 enabled edges after that start edge. In free-running mode the second flag is due 2(N+1) edges after it. Every bus access in the bench consumes exactly one edge. The bench counts edges from the start write, includes those bus accesses in the count, and samples one time unit after each edge. Register reads are combinational, so they are sampled before the edge that would decrement the counter or clear the flag.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    typedef enum logic [1:0] {
        RA_CNT_LO = 2'd0,
        RA_START  = 2'd1,
        RA_LAT_LO = 2'd2,
        RA_LAT_HI = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic pin_en;
        logic free_run;
    } mode_t;

    // Byte lanes of the reload latch that a write address targets.
    function automatic logic [1:0] latch_lanes(input reg_addr_e ra);
        logic [1:0] lanes;
        lanes = 2'b00;
        unique case (ra)
            RA_CNT_LO: lanes = 2'b01;
            RA_LAT_LO: lanes = 2'b01;
            RA_START:  lanes = 2'b10;
            RA_LAT_HI: lanes = 2'b10;
        endcase
        return lanes;
    endfunction

    // Addresses whose write clears the interrupt flag.
    function automatic logic write_clears(input reg_addr_e ra);
        return (ra == RA_START) || (ra == RA_LAT_HI);
    endfunction

endpackage

// File: rtl/dlt_regs.sv
module dlt_regs
    import dlt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic [2*DW-1:0]   cnt,
    output logic [2*DW-1:0]   latch,
    output logic              start,
    output logic              bus_clr,
    output logic [DW-1:0]     rdata
);
    localparam int NB = 2;

    reg_addr_e         ra;
    logic              wr_cyc;
    logic              rd_cyc;
    logic [NB-1:0]     lane_we;

    assign ra     = reg_addr_e'(addr);
    assign wr_cyc = sel && wr;
    assign rd_cyc = sel && !wr;

    always_comb begin
        lane_we = '0;
        if (wr_cyc) begin
            lane_we = latch_lanes(ra);
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                latch[b*DW +: DW] <= '0;
            end else if (lane_we[b]) begin
                latch[b*DW +: DW] <= wdata;
            end
        end
    end

    assign start   = wr_cyc && (ra == RA_START);
    assign bus_clr = (wr_cyc && write_clears(ra)) || (rd_cyc && (ra == RA_CNT_LO));

    always_comb begin
        rdata = '0;
        if (rd_cyc) begin
            unique case (ra)
                RA_CNT_LO: rdata = cnt[DW-1:0];
                RA_START:  rdata = cnt[2*DW-1:DW];
                RA_LAT_LO: rdata = latch[DW-1:0];
                RA_LAT_HI: rdata = latch[2*DW-1:DW];
            endcase
        end
    end

endmodule

// File: rtl/dlt_count.sv
module dlt_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic [CW-1:0] start_val,
    input  logic [CW-1:0] reload_val,
    input  logic          free_run,
    output logic [CW-1:0] cnt,
    output logic          expire,
    output logic          fire
);
    logic armed;

    assign expire = tick && !start && (cnt == '0);
    assign fire   = expire && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start) begin
            cnt   <= start_val;
            armed <= 1'b1;
        end else if (tick) begin
            if (expire && free_run) begin
                cnt <= reload_val;
            end else begin
                cnt <= cnt - 1'b1;
            end
            if (expire && !free_run) begin
                armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dlt_pinflag.sv
module dlt_pinflag (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic start,
    input  logic clr_req,
    input  logic free_run,
    input  logic pin_en,
    input  logic gpio_bit,
    output logic irq_flag,
    output logic pin_q,
    output logic pin_out,
    output logic pin_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (fire) begin
            irq_flag <= 1'b1;
        end else if (clr_req) begin
            irq_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b1;
        end else if (start) begin
            pin_q <= 1'b0;
        end else if (fire) begin
            pin_q <= free_run ? ~pin_q : 1'b1;
        end
    end

    assign pin_oe  = pin_en;
    assign pin_out = pin_en ? pin_q : gpio_bit;

endmodule

// File: rtl/dlt_timer.sv
module dlt_timer
    import dlt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          sel,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [1:0]    mode,
    input  logic          gpio_bit,
    input  logic          flag_clr,
    output logic          irq_flag,
    output logic          pin_out,
    output logic          pin_oe
);
    localparam int CW = 2 * DW;

    mode_t          md;
    logic [CW-1:0]  latch;
    logic [CW-1:0]  cnt;
    logic           start;
    logic           bus_clr;
    logic           expire;
    logic           fire;
    logic           pin_q;

    assign md = mode_t'(mode);

    dlt_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt),
        .latch   (latch),
        .start   (start),
        .bus_clr (bus_clr),
        .rdata   (rdata)
    );

    dlt_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_en),
        .start      (start),
        .start_val  ({wdata, latch[DW-1:0]}),
        .reload_val (latch),
        .free_run   (md.free_run),
        .cnt        (cnt),
        .expire     (expire),
        .fire       (fire)
    );

    dlt_pinflag u_pinflag (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .start    (start),
        .clr_req  (bus_clr || flag_clr),
        .free_run (md.free_run),
        .pin_en   (md.pin_en),
        .gpio_bit (gpio_bit),
        .irq_flag (irq_flag),
        .pin_q    (pin_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/dlt_timer_chk.sv
module dlt_timer_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            tick_en,
    input logic            start,
    input logic [DW-1:0]   wdata,
    input logic [2*DW-1:0] latch,
    input logic [2*DW-1:0] cnt,
    input logic            expire,
    input logic            fire,
    input logic [1:0]      mode,
    input logic            irq_flag,
    input logic            pin_q
);
    a_r3_start_loads: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt == {$past(wdata), $past(latch[DW-1:0])});

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !start) |=> $stable(cnt));

    a_r5_flag_rises: assert property (@(posedge clk) disable iff (rst)
        fire |=> irq_flag);

    a_r7_free_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && mode[0]) |=> cnt == $past(latch));

    a_r6_oneshot_wrap: assert property (@(posedge clk) disable iff (rst)
        (expire && !mode[0]) |=> &cnt);

    a_r9_start_pin_low: assert property (@(posedge clk) disable iff (rst)
        start |=> !pin_q);

    a_r9_oneshot_pin_high: assert property (@(posedge clk) disable iff (rst)
        (fire && !mode[0]) |=> pin_q);

endmodule

bind dlt_timer dlt_timer_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .start    (start),
    .wdata    (wdata),
    .latch    (latch),
    .cnt      (cnt),
    .expire   (expire),
    .fire     (fire),
    .mode     (mode),
    .irq_flag (irq_flag),
    .pin_q    (pin_q)
);

// File: tb/dlt_timer_test.sv
module dlt_timer_test;
    localparam int CLK_P = 10;
    localparam int NV    = 4;
    // entry: {low byte, high byte, mode, ticks to first flag}
    localparam logic [41:0] VEC [NV] = '{
        {8'h03, 8'h00, 2'b10, 24'd4},
        {8'h00, 8'h00, 2'b00, 24'd1},
        {8'h10, 8'h00, 2'b11, 24'd17},
        {8'h05, 8'h01, 2'b01, 24'd262}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       sel = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] mode = 2'b10;
    logic       gpio_bit = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_flag;
    logic       pin_out;
    logic       pin_oe;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    dlt_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sel(sel), .addr(addr),
        .wr(wr), .wdata(wdata), .rdata(rdata), .mode(mode),
        .gpio_bit(gpio_bit), .flag_clr(flag_clr), .irq_flag(irq_flag),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
    endtask

    task automatic wait_flag(inout int n);
        while (!irq_flag && n < 150000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 flag", irq_flag, 0);
        chk("R1 pin", pin_out, 1);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], d);
            chk("R1 regs", d, 0);
        end

        // vector table: R5 timing, R7 period, R9 pin shape
        tick_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [7:0] lo, hi;
            logic [1:0] md;
            int ex;
            {lo, hi, md, ex} = {VEC[v][41:34], VEC[v][33:26], VEC[v][25:24], 32'(VEC[v][23:0])};
            @(negedge clk) mode = md;
            wr_reg((v % 2 == 0) ? 2'd0 : 2'd2, lo);
            wr_reg(2'd1, hi);
            if (md[1]) chk("R9 pin low after start", pin_out, 0);
            n = 0;
            wait_flag(n);
            chk("R5 first flag", n, ex);
            if (md[1]) chk("R9 pin at first timeout", pin_out, 1);
            if (md[0]) begin
                pulse_clr();
                n++;
                chk("R8 flag_clr", irq_flag, 0);
                wait_flag(n);
                chk("R7 second flag", n, 2 * ex);
                if (md[1]) chk("R9 square toggles", pin_out, 0);
            end
        end

        // R4 tick gating
        @(negedge clk) begin tick_en = 1'b0; mode = 2'b10; end
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd1, 8'h00);
        repeat (10) @(posedge clk);
        #1 chk("R4 no flag while idle", irq_flag, 0);
        rd_reg(2'd0, d);
        chk("R4 held count", d, 8'h02);
        @(negedge clk) tick_en = 1'b1;
        n = 0;
        wait_flag(n);
        chk("R5 flag after N+1 ticks", n, 3);

        // R6 one-shot wraps and keeps counting, no refire
        rd_reg(2'd1, d);
        chk("R6 wrapped high byte", d, 8'hFF);
        rd_reg(2'd0, d);
        chk("R6 still counting", d, 8'hFE);
        chk("R8 low read clears flag", irq_flag, 0);
        repeat (70000) @(posedge clk);
        #1 chk("R6 no second flag", irq_flag, 0);

        // R2 latch writes do not disturb count
        @(negedge clk) mode = 2'b00;
        wr_reg(2'd0, 8'h14);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h55);
        wr_reg(2'd3, 8'h01);
        n = 2;
        wait_flag(n);
        chk("R2 count undisturbed", n, 21);
        rd_reg(2'd2, d);
        chk("R2 low latch", d, 8'h55);
        rd_reg(2'd3, d);
        chk("R2 high latch", d, 8'h01);
        wr_reg(2'd3, 8'h01);
        chk("R8 high latch write clears", irq_flag, 0);

        // R7 reload takes latch value written mid-count
        @(negedge clk) mode = 2'b01;
        wr_reg(2'd2, 8'h03);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h06);
        n = 1;
        wait_flag(n);
        chk("R7 first period", n, 4);
        pulse_clr();
        n++;
        wait_flag(n);
        chk("R7 reload from new latch", n, 11);

        // R3 start write
        wr_reg(2'd1, 8'h7A);
        chk("R3 start clears flag", irq_flag, 0);
        rd_reg(2'd3, d);
        chk("R3 high latch loaded", d, 8'h7A);
        rd_reg(2'd1, d);
        chk("R3 high counter loaded", d, 8'h7A);

        // R8 set wins over clear
        @(negedge clk) mode = 2'b00;
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h00);
        pulse_clr();
        chk("R8 set beats clear", irq_flag, 1);
        pulse_clr();
        chk("R8 clear input", irq_flag, 0);

        // R10 pin mux
        @(negedge clk) gpio_bit = 1'b1;
        #1 chk("R10 gpio high", pin_out, 1);
        chk("R10 oe off", pin_oe, 0);
        @(negedge clk) gpio_bit = 1'b0;
        #1 chk("R10 gpio low", pin_out, 0);
        @(negedge clk) mode = 2'b10;
        #1 chk("R10 timer drives pin", pin_out, 1);
        chk("R10 oe on", pin_oe, 1);
        wr_reg(2'd2, 8'h05);
        wr_reg(2'd1, 8'h00);
        @(negedge clk) gpio_bit = 1'b1;
        #1 chk("R10 gpio ignored", pin_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule